// File: doc/BRIEF.md
# Branch-Condition and Program-Counter Sequencer

This block is the program-counter unit of a small RISC integer core. It holds a four-bit condition-flag register, which only flag-setting instructions write, and it evaluates the sixteen branch conditions against those flags. It also keeps two counters: the address of the instruction being executed (PC) and the address that follows it (nPC). Every control transfer changes nPC and never PC directly. As a result, the instruction that follows a branch, call or return always executes. This is the delay slot.

The decode stage presents one instruction per cycle. That instruction may carry an ALU result with its carry and overflow and a request to update the flags. It may instead carry a branch condition code and target, a call strobe with its target, or a leaf-return strobe with the saved link value. A stall input freezes the sequencer. The link output gives the value that the register file writes into register 15 on a call.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is high, PC is 0, nPC is 4, the link output is 0, the taken flag is 0 and all four flags (Z, N, C, V) are 0. The flags are observable only through branch outcomes.
- R2: When the flag-update input is low, the flags keep their value whatever the ALU result, carry and overflow inputs are.
- R3: A flag update with the sequencer not stalled loads Z with (result == 0), N with result bit 31, C with the carry input and V with the overflow input.
- R4: The branch code selects a condition. In the lower half: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V. Codes 8 to 15 are the logical inverse of codes 0 to 7 in the same order, so 8 is always and 9 is !Z. Each condition is evaluated on the flags held before the cycle.
- R5: When the sequencer is not stalled and no transfer is requested, PC takes the old nPC and nPC becomes the old nPC plus 4.
- R6: On a branch, PC takes the old nPC. nPC takes the target if the condition holds and otherwise the old nPC plus 4. The target therefore reaches PC one instruction later. The taken output is high for the cycle after a taken branch.
- R7: A call loads the link output with the PC of the call instruction, sets nPC to the call target and raises taken in the following cycle.
- R8: A leaf return sets nPC to the supplied link value plus 8 and raises taken in the following cycle.
- R9: While stall is high, PC, nPC, the flags and the link output hold their values and taken is 0.
- R10: When several transfer strobes are high together, call wins over return and return wins over branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze all state this cycle |
| alu_res | input | 32 | ALU result of the current instruction |
| alu_carry | input | 1 | Carry out of the result MSB |
| alu_ovf | input | 1 | Signed overflow of the result |
| flag_wr | input | 1 | Instruction is a flag-setting variant |
| br_valid | input | 1 | Instruction is a conditional branch |
| br_cond | input | 4 | Branch condition code |
| br_target | input | 32 | Branch target address |
| call_valid | input | 1 | Instruction is a call-and-link |
| call_target | input | 32 | Call target address |
| ret_valid | input | 1 | Instruction is a leaf return |
| ret_link | input | 32 | Saved link value (register 15) |
| pc | output | 32 | Address of the current instruction |
| link | output | 32 | Value to write into register 15 |
| taken | output | 1 | Previous step redirected nPC |

## Verification
The assertions check on every cycle that a stall freezes PC and nPC, that the flags change only on an unstalled update, and that each accepted step moves nPC into PC. They also check the three redirection cases: branch target, call link, and return plus eight. Which flag combination makes each of the sixteen codes true can be shown only by the bench scenarios. The same goes for the encoding of Z, N, C and V from real results, the one-instruction delay before a target reaches PC, and the priority between simultaneous strobes. The bench sweeps every code under several flag patterns to show these.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  localparam logic [3:0] COND_NEVER  = 4'h0;
  localparam logic [3:0] COND_ALWAYS = 4'h8;
endpackage

// File: rtl/flag_reg.sv
module flag_reg
  import pc_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          upd,
  input  logic [DW-1:0] res,
  input  logic          carry,
  input  logic          ovf,
  output flags_t        flags_q
);
  localparam int MSB = DW - 1;

  flags_t flags_d;

  always_comb begin
    flags_d.z = (res == '0);
    flags_d.n = res[MSB];
    flags_d.c = carry;
    flags_d.v = ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else if (upd && !stall) flags_q <= flags_d;
  end

  // R2
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd || stall) |=> $stable(flags_q));
  // R3
  flags_load_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && !stall) |=> (flags_q.c == $past(carry)) && (flags_q.v == $past(ovf)));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import pc_seq_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] code,
  output logic       hit
);
  logic base;

  always_comb begin
    unique case (code[2:0])
      3'd0: base = 1'b0;
      3'd1: base = flags.z;
      3'd2: base = flags.z | (flags.n ^ flags.v);
      3'd3: base = flags.n ^ flags.v;
      3'd4: base = flags.c | flags.z;
      3'd5: base = flags.c;
      3'd6: base = flags.n;
      default: base = flags.v;
    endcase
    hit = base ^ code[3];
  end

  // R4
  always_comb begin
    never_always_chk: assert ((code != COND_NEVER || !hit) && (code != COND_ALWAYS || hit));
  end
endmodule

// File: rtl/pc_ctrl.sv
module pc_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          br_valid,
  input  logic          br_hit,
  input  logic [AW-1:0] br_target,
  input  logic          call_valid,
  input  logic [AW-1:0] call_target,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_link,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] link_q,
  output logic          taken_q
);
  localparam logic [AW-1:0] STEP    = AW'(4);
  localparam logic [AW-1:0] RET_OFS = AW'(8);
  localparam logic [AW-1:0] NPC_RST = STEP;

  logic [AW-1:0] npc_q;
  logic [AW-1:0] npc_d;
  logic          redirect;

  always_comb begin
    redirect = 1'b1;
    if (call_valid)              npc_d = call_target;
    else if (ret_valid)          npc_d = ret_link + RET_OFS;
    else if (br_valid && br_hit) npc_d = br_target;
    else begin
      npc_d    = npc_q + STEP;
      redirect = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      npc_q   <= NPC_RST;
      link_q  <= '0;
      taken_q <= 1'b0;
    end else if (stall) begin
      taken_q <= 1'b0;
    end else begin
      pc_q    <= npc_q;
      npc_q   <= npc_d;
      taken_q <= redirect;
      if (call_valid) link_q <= pc_q;
    end
  end

  // R9
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc_q) && $stable(npc_q) && $stable(link_q) && !taken_q);
  // R5
  step_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !call_valid && !ret_valid && !br_valid) |=>
      (pc_q == $past(npc_q)) && (npc_q == $past(npc_q) + STEP) && !taken_q);
  // R6
  branch_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !call_valid && !ret_valid && br_valid && br_hit) |=>
      (npc_q == $past(br_target)) && (pc_q == $past(npc_q)) && taken_q);
  // R7
  call_link_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && call_valid) |=> (link_q == $past(pc_q)) && (npc_q == $past(call_target)));
  // R8
  ret_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !call_valid && ret_valid) |=> (npc_q == $past(ret_link) + RET_OFS));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic [DW-1:0] alu_res,
  input  logic          alu_carry,
  input  logic          alu_ovf,
  input  logic          flag_wr,
  input  logic          br_valid,
  input  logic [3:0]    br_cond,
  input  logic [AW-1:0] br_target,
  input  logic          call_valid,
  input  logic [AW-1:0] call_target,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_link,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] link,
  output logic          taken
);
  flags_t flags;
  logic   hit;

  flag_reg #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst), .stall(stall), .upd(flag_wr),
    .res(alu_res), .carry(alu_carry), .ovf(alu_ovf), .flags_q(flags)
  );

  cond_eval u_cond (
    .flags(flags), .code(br_cond), .hit(hit)
  );

  pc_ctrl #(.AW(AW)) u_pc (
    .clk(clk), .rst(rst), .stall(stall),
    .br_valid(br_valid), .br_hit(hit), .br_target(br_target),
    .call_valid(call_valid), .call_target(call_target),
    .ret_valid(ret_valid), .ret_link(ret_link),
    .pc_q(pc), .link_q(link), .taken_q(taken)
  );
endmodule

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] alu_res = '0;
  logic        alu_carry = 1'b0, alu_ovf = 1'b0, flag_wr = 1'b0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [31:0] br_target = '0;
  logic        call_valid = 1'b0;
  logic [31:0] call_target = '0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_link = '0;
  logic [31:0] pc, link;
  logic        taken;

  int total = 0, bad = 0;
  logic [31:0] m_pc, m_npc, m_link;
  logic        m_taken, fz, fn, fc, fv;

  always #2.5 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst(rst), .stall(stall), .alu_res(alu_res), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .flag_wr(flag_wr), .br_valid(br_valid), .br_cond(br_cond),
    .br_target(br_target), .call_valid(call_valid), .call_target(call_target),
    .ret_valid(ret_valid), .ret_link(ret_link), .pc(pc), .link(link), .taken(taken)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_ok(logic [3:0] c);
    case (c)
      4'h0: return 1'b0;
      4'h1: return fz;
      4'h2: return fz | (fn ^ fv);
      4'h3: return fn ^ fv;
      4'h4: return fc | fz;
      4'h5: return fc;
      4'h6: return fn;
      4'h7: return fv;
      4'h8: return 1'b1;
      4'h9: return !fz;
      4'hA: return !(fz | (fn ^ fv));
      4'hB: return !(fn ^ fv);
      4'hC: return !(fc | fz);
      4'hD: return !fc;
      4'hE: return !fn;
      default: return !fv;
    endcase
  endfunction

  // one instruction: inputs already driven at negedge; model, clock, check
  task automatic tick(string req);
    logic [31:0] nn;
    m_taken = 1'b0;
    if (!stall) begin
      if (call_valid) begin m_link = m_pc; nn = call_target; m_taken = 1'b1; end
      else if (ret_valid) begin nn = ret_link + 32'd8; m_taken = 1'b1; end
      else if (br_valid && cond_ok(br_cond)) begin nn = br_target; m_taken = 1'b1; end
      else nn = m_npc + 32'd4;
      m_pc = m_npc;
      m_npc = nn;
      if (flag_wr) begin
        fz = (alu_res == 0); fn = alu_res[31]; fc = alu_carry; fv = alu_ovf;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " pc"}, pc, m_pc);
    chk({req, " taken"}, {31'd0, taken}, {31'd0, m_taken});
    chk({req, " link"}, link, m_link);
    stall = 0; flag_wr = 0; br_valid = 0; call_valid = 0; ret_valid = 0;
    alu_res = 0; alu_carry = 0; alu_ovf = 0;
  endtask

  task automatic set_flags(logic [31:0] r, logic cy, logic ov);
    alu_res = r; alu_carry = cy; alu_ovf = ov; flag_wr = 1;
    tick("R3 flag update");
  endtask

  task automatic sweep_codes(string req);
    for (int k = 0; k < 16; k++) begin
      br_valid = 1; br_cond = 4'(k); br_target = 32'h0000_1000 + 32'(k * 16);
      tick(req);
      tick("R6 delay slot");
    end
  endtask

  task automatic t_reset;
    chk("R1 reset pc", pc, 32'd0);
    chk("R1 reset taken", {31'd0, taken}, 32'd0);
    chk("R1 reset link", link, 32'd0);
    tick("R5 first step");
    chk("R1 npc was 4", pc, 32'd4);
    tick("R5 step");
    sweep_codes("R1 R4 zero flags");
  endtask

  task automatic t_conditions;
    set_flags(32'd0, 0, 0);          sweep_codes("R4 Z");
    set_flags(32'h8000_0000, 0, 0);  sweep_codes("R4 N");
    set_flags(32'h0000_0005, 1, 0);  sweep_codes("R4 C");
    set_flags(32'h0000_0005, 0, 1);  sweep_codes("R4 V");
    set_flags(32'h8000_0001, 0, 1);  sweep_codes("R4 N V");
    set_flags(32'h0000_0000, 1, 1);  sweep_codes("R4 ZCV");
  endtask

  task automatic t_no_update;
    set_flags(32'd0, 0, 0);
    alu_res = 32'h8000_0001; alu_carry = 1; alu_ovf = 1;
    tick("R2 plain op");
    br_valid = 1; br_cond = 4'h1; br_target = 32'h2000;
    tick("R2 Z kept");
    br_valid = 1; br_cond = 4'h5; br_target = 32'h2100;
    tick("R2 C kept");
  endtask

  task automatic t_stall;
    stall = 1; br_valid = 1; br_cond = 4'h8; br_target = 32'h3000;
    flag_wr = 1; alu_res = 32'h8000_0000; alu_carry = 1;
    tick("R9 stall");
    stall = 1; call_valid = 1; call_target = 32'h3300;
    tick("R9 stall call");
    br_valid = 1; br_cond = 4'h1; br_target = 32'h3100;
    tick("R9 flags held");
    tick("R5 step");
  endtask

  task automatic t_call_ret;
    call_valid = 1; call_target = 32'h4000;
    tick("R7 call");
    tick("R7 delay slot");
    chk("R7 at target", pc, 32'h4000);
    tick("R5 body");
    ret_valid = 1; ret_link = m_link;
    tick("R8 return");
    tick("R8 delay slot");
    tick("R8 resume");
  endtask

  task automatic t_priority;
    set_flags(32'd0, 0, 0);
    call_valid = 1; call_target = 32'h5000;
    ret_valid = 1; ret_link = 32'h6000;
    br_valid = 1; br_cond = 4'h8; br_target = 32'h7000;
    tick("R10 call wins");
    tick("R10 slot");
    ret_valid = 1; ret_link = 32'h6000;
    br_valid = 1; br_cond = 4'h8; br_target = 32'h7000;
    tick("R10 ret wins");
    tick("R10 slot");
    chk("R10 ret target", pc, 32'h6008);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_pc = 0; m_npc = 4; m_link = 0; fz = 0; fn = 0; fc = 0; fv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_conditions();
    t_no_update();
    t_stall();
    t_call_ret();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule